// File: doc/BRIEF.md
# Converter Clock and Alignment Pulse Generator

This block derives a steady, gateable clock for a downstream oversampling converter from the chip's synchronous system clock. It also produces a one-period alignment pulse whenever an external, asynchronous alignment request goes from low to high. A free-running phase counter divides the system clock by `2*HALF`, and the converter clock is taken from a register, never from a gated net. A separate strobe marks every `STB_DIV`-th converter clock period, so that a serial bitstream source can advance one bit per strobe.

Both outputs are off after reset. The clock output starts only after software sets its enable bit through a single-cycle configuration write. Enabling and disabling take effect only at a phase boundary, where the clock output is low, so the clock never produces a shortened high pulse. When it is disabled it stays low for as long as the bit stays clear, and the downstream part relies on that to detect a stopped clock.

An alignment request passes through a two-flop synchronizer and a rising-edge detector. The pulse that results starts on the next converter clock rising edge. The same edge restarts the strobe count, so that the bitstream frames line up with the pulse.

Top module: `cvt_clk_sync_gen`

## Requirements
- R1: The phase counter starts at zero on reset release and advances on every system clock edge. It wraps every `2*HALF` edges, so phase boundaries fall on clock edges `n` (counted from release) with `n % (2*HALF) == 0`. While gating is on, `conv_clk` is 1 during the first `HALF` cycles after a boundary and 0 for the next `HALF` cycles.
- R2: While `rst_n` is low, `conv_clk`, `frame_sync` and `bit_stb` are 0, and both enable bits read as cleared.
- R3: A write is a cycle with `cfg_we` = 1. `cfg_wdata` bit 0 is the clock enable and bit 1 is the alignment pulse enable. Both are stored at the edge that samples the write.
- R4: The clock gate takes the stored clock enable only at a phase boundary. Every high pulse of `conv_clk` therefore lasts exactly `HALF` cycles, and `conv_clk` stays 0 at every boundary that sees the enable cleared.
- R5: Suppose `align_req` is first sampled high at edge k after being sampled low at edge k-1, and the pulse enable is set. Then `frame_sync` rises at the first phase boundary edge at or after k+2 and stays high for one full period of `2*HALF` cycles.
- R6: While the pulse enable is clear, rising edges of `align_req` produce no `frame_sync`. A steady high or low level never produces one.
- R7: `bit_stb` is a one-cycle pulse that coincides with a rising edge of `conv_clk`. It occurs at every `STB_DIV`-th phase boundary, counted from reset or from the start of the last `frame_sync` period, which itself counts as a strobe boundary. It occurs only while gating is on.
- R8: Several rising edges of `align_req` that fall before the same phase boundary give one pulse period. A rising edge that is detected while `frame_sync` is high extends the pulse by exactly one more period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 2 | Configuration data: bit 0 clock enable, bit 1 pulse enable |
| align_req | input | 1 | Asynchronous alignment request |
| conv_clk | output | 1 | Gated converter clock, system clock divided by 2*HALF |
| frame_sync | output | 1 | Alignment pulse, one converter clock period wide |
| bit_stb | output | 1 | One-cycle strobe every STB_DIV converter clock periods |

## Verification
The bench sweeps enable writes across every phase offset, including writes that land in the middle of a high half. A design that gated anywhere other than a boundary would emit a short pulse or cut one off early. Alignment requests are swept across every offset within a full strobe frame, with one to three cycles of width. This exposes an off-by-one in synchronizer latency, a pulse that starts off a rising edge, or a strobe count that is not restarted. Closely spaced requests, a long high level, requests while the pulse enable is clear, and requests while the clock is gated off separate edge detection from level detection and show whether the strobe is correctly tied to the gate.

// File: rtl/cks_pkg.sv
package cks_pkg;

    localparam int CFG_CLK_BIT   = 0;
    localparam int CFG_PULSE_BIT = 1;
    localparam int CFG_W         = 2;

    typedef struct packed {
        logic pulse_en;
        logic clk_en;
    } cfg_t;

endpackage

// File: rtl/cks_phase_div.sv
module cks_phase_div #(
    parameter int HALF = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    output logic [$clog2(2*HALF)-1:0]     phase,
    output logic                          wrap,
    output logic                          hi_next
);
    localparam int PER = 2 * HALF;
    localparam int PW  = $clog2(PER);
    localparam logic [PW-1:0] LAST   = PW'(PER - 1);
    localparam logic [PW-1:0] HALF_V = PW'(HALF);

    logic [PW-1:0] phase_d, phase_q;

    always_comb begin
        wrap    = (phase_q == LAST);
        phase_d = wrap ? '0 : phase_q + 1'b1;
        hi_next = (phase_d < HALF_V);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

    assign phase = phase_q;
endmodule

// File: rtl/cks_edge_sync.sv
module cks_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    typedef struct packed {
        logic meta;
        logic stable;
        logic prev;
    } chain_t;

    chain_t s_d, s_q;

    always_comb begin
        s_d.meta   = async_in;
        s_d.stable = s_q.meta;
        s_d.prev   = s_q.stable;
        rise       = s_q.stable & ~s_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/cks_bit_strobe.sv
module cks_bit_strobe #(
    parameter int STB_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic restart,
    input  logic gate_next,
    output logic stb
);
    localparam int SW = (STB_DIV > 2) ? $clog2(STB_DIV) : 1;
    localparam logic [SW-1:0] LAST = SW'(STB_DIV - 1);

    typedef struct packed {
        logic [SW-1:0] cnt;
        logic          stb;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (restart)
            s_d.cnt = '0;
        else if (wrap)
            s_d.cnt = (s_q.cnt == LAST) ? '0 : s_q.cnt + 1'b1;
        s_d.stb = wrap & gate_next & (s_d.cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign stb = s_q.stb;
endmodule

// File: rtl/cvt_clk_sync_gen.sv
module cvt_clk_sync_gen
    import cks_pkg::*;
#(
    parameter int HALF    = 8,
    parameter int STB_DIV = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             align_req,
    output logic             conv_clk,
    output logic             frame_sync,
    output logic             bit_stb
);
    localparam int PW = $clog2(2 * HALF);

    typedef struct packed {
        cfg_t cfg;
        logic gate;
        logic cclk;
        logic pend;
        logic fsync;
    } top_t;

    logic [PW-1:0] phase;
    logic          wrap;
    logic          hi_next;
    logic          rise;
    logic          rise_en;
    logic          restart;
    top_t          s_d, s_q;

    cks_phase_div #(.HALF(HALF)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase),
        .wrap    (wrap),
        .hi_next (hi_next)
    );

    cks_edge_sync u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (align_req),
        .rise     (rise)
    );

    always_comb begin
        s_d     = s_q;
        rise_en = rise & s_q.cfg.pulse_en;
        if (cfg_we) begin
            s_d.cfg.clk_en   = cfg_wdata[CFG_CLK_BIT];
            s_d.cfg.pulse_en = cfg_wdata[CFG_PULSE_BIT];
        end
        s_d.gate = wrap ? s_q.cfg.clk_en : s_q.gate;
        s_d.cclk = s_d.gate & hi_next;
        if (wrap) begin
            s_d.fsync = s_q.pend | rise_en;
            s_d.pend  = 1'b0;
        end else begin
            s_d.pend  = s_q.pend | rise_en;
        end
        restart = wrap & (s_q.pend | rise_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    cks_bit_strobe #(.STB_DIV(STB_DIV)) u_stb (
        .clk       (clk),
        .rst_n     (rst_n),
        .wrap      (wrap),
        .restart   (restart),
        .gate_next (s_d.gate),
        .stb       (bit_stb)
    );

    assign conv_clk   = s_q.cclk;
    assign frame_sync = s_q.fsync;
endmodule

// File: rtl/cvt_clk_sync_chk.sv
module cvt_clk_sync_chk #(
    parameter int HALF = 8,
    parameter int PW   = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          conv_clk,
    input logic          frame_sync,
    input logic          bit_stb,
    input logic          clk_en,
    input logic [PW-1:0] phase
);
    localparam int PER = 2 * HALF;

    int hi_cnt;
    int fs_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= 0;
            fs_cnt <= 0;
        end else begin
            hi_cnt <= conv_clk   ? hi_cnt + 1 : 0;
            fs_cnt <= frame_sync ? fs_cnt + 1 : 0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!conv_clk && !frame_sync && !bit_stb); // R2
        end
    end

    AST_FULL_HIGH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_clk) |-> hi_cnt == HALF); // R4

    AST_NO_START_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!clk_en) |-> !$rose(conv_clk)); // R3

    AST_PULSE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frame_sync) |-> phase == '0); // R5

    AST_PULSE_WHOLE_PERIODS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_sync) |-> (fs_cnt % PER) == 0); // R8

    AST_STROBE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |-> $rose(conv_clk)); // R7
endmodule

bind cvt_clk_sync_gen cvt_clk_sync_chk #(.HALF(HALF), .PW(PW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_clk   (conv_clk),
    .frame_sync (frame_sync),
    .bit_stb    (bit_stb),
    .clk_en     (s_q.cfg.clk_en),
    .phase      (phase)
);

// File: tb/cvt_clk_sync_gen_tb.sv
module cvt_clk_sync_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;
    localparam int STB_DIV    = 8;
    localparam int PER        = 2 * HALF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_wdata = 2'b00;
    logic       align_req = 1'b0;
    logic       conv_clk, frame_sync, bit_stb;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    string cur    = "R2";

    // bench-side expectation state
    int n = 0, bc = 0, pend_at = 0;
    bit exp_gate = 0, exp_fs = 0, exp_stb = 0, pend = 0;
    bit m_clk_en = 0, m_pulse_en = 0, s_last = 0;

    cvt_clk_sync_gen #(.HALF(HALF), .STB_DIV(STB_DIV)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .align_req  (align_req),
        .conv_clk   (conv_clk),
        .frame_sync (frame_sync),
        .bit_stb    (bit_stb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            n = 0; bc = 0; pend = 0; pend_at = 0;
            exp_gate = 0; exp_fs = 0; exp_stb = 0;
            m_clk_en = 0; m_pulse_en = 0; s_last = 0;
        end else begin
            n = n + 1;
            if (n % PER == 0) begin
                exp_gate = m_clk_en;
                if (pend && pend_at <= n) begin
                    exp_fs = 1; pend = 0; bc = 0;
                end else begin
                    exp_fs = 0; bc = (bc + 1) % STB_DIV;
                end
                exp_stb = exp_gate && (bc == 0);
            end else begin
                exp_stb = 0;
            end
            if (align_req && !s_last && m_pulse_en && !pend) begin
                pend = 1; pend_at = n + 2;
            end
            s_last = align_req;
            if (cfg_we) begin
                m_clk_en   = cfg_wdata[0];
                m_pulse_en = cfg_wdata[1];
            end
        end
    end

    task automatic chk(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s [%s] cycle %0d: got %0b expected %0b", req, cur, n, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                chk(conv_clk,   1'b0, "R2 conv_clk");
                chk(frame_sync, 1'b0, "R2 frame_sync");
                chk(bit_stb,    1'b0, "R2 bit_stb");
            end else begin
                chk(conv_clk,   exp_gate && ((n % PER) < HALF), "R1 R4 conv_clk");
                chk(frame_sync, exp_fs,  "R5 frame_sync");
                chk(bit_stb,    exp_stb, "R7 bit_stb");
            end
        end
    end

    task automatic wait_cyc(input int c);
        repeat (c) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [1:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic req_pulse(input int w);
        @(negedge clk);
        align_req = 1'b1;
        wait_cyc(w);
        align_req = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        cur = "R2 reset";
        wait_cyc(5);
        rst_n = 1'b1;

        cur = "R2 R6 idle after reset";
        wait_cyc(10);
        req_pulse(2);
        wait_cyc(30);

        cur = "R3 R1 clock enable";
        cfg_write(2'b01);
        wait_cyc(40);

        cur = "R4 R3 enable sweep";
        for (int i = 0; i < 2 * PER; i++) begin
            wait_cyc(i);
            cfg_write(2'b00);
            wait_cyc(i + 3);
            cfg_write(2'b01);
        end
        wait_cyc(10);

        cur = "R5 R7 request offset sweep";
        cfg_write(2'b11);
        wait_cyc(6);
        for (int off = 0; off < PER * STB_DIV + PER; off++) begin
            wait_cyc(off);
            req_pulse(1 + (off % 3));
            wait_cyc(60);
        end

        cur = "R8 close requests";
        for (int g = 1; g < PER + 3; g++) begin
            req_pulse(1);
            wait_cyc(g);
            req_pulse(1);
            wait_cyc(60);
        end
        for (int g = 0; g < PER; g++) begin
            req_pulse(1);
            wait_cyc(PER + 2 + g);
            req_pulse(1);
            wait_cyc(60);
        end

        cur = "R6 R8 steady level";
        req_pulse(50);
        wait_cyc(40);

        cur = "R6 pulse enable clear";
        cfg_write(2'b01);
        wait_cyc(6);
        for (int k = 0; k < PER + 2; k++) begin
            wait_cyc(k);
            req_pulse(1 + k % 2);
            wait_cyc(20);
        end

        cur = "R7 clock gated off, pulses on";
        cfg_write(2'b10);
        wait_cyc(6);
        for (int k = 0; k < PER; k++) begin
            wait_cyc(k);
            req_pulse(1);
            wait_cyc(40);
        end
        cfg_write(2'b11);
        wait_cyc(80);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule